// File: doc/BRIEF.md
# Four-Bank Tightly Coupled Data Memory Arbiter

This block sits between the requesters of a tightly coupled data memory and the four 32-bit single-port SRAM banks behind it. The banks are interleaved on word address bits [3:2], so consecutive 32-bit words fall into consecutive banks and the array can move 128 bits per cycle when every bank is busy. Two 32-bit processor data ports, which may both request in the same cycle, and one 64-bit DMA port share the banks. Every cycle the block decodes each request into a bank, resolves conflicts, returns the grants combinationally in the request cycle, and drives the winning requester's address, write data and byte enables onto each bank.

Processor ports outrank DMA on any shared bank, and processor port 0 outranks port 1. A stalled requester holds its request until it is granted. DMA transfers are 64 bits wide and occupy an aligned pair of banks at once; to keep DMA from starving behind a busy processor, a DMA request that has lost several cycles in a row is served first for one cycle. Read data comes back one cycle after the grant on the requesting port, marked by that port's valid. A misaligned DMA request is consumed with an error response and never reaches a bank.

Top module: `tcm_bank_arbiter`

## Requirements
- R1: A processor access to byte address A uses bank A[3:2] at row A[AW-1:4]; a granted processor access enables exactly that bank in the grant cycle.
- R2: Two processor requests to different banks are both granted in the same cycle.
- R3: When both processor ports request the same bank, port 0 is granted and port 1 is not granted in that cycle.
- R4: An aligned DMA access at address A (A[2:0]=0) uses banks 2*A[3] (data bits 31:0, byte enables 3:0) and 2*A[3]+1 (data bits 63:32, byte enables 7:4) in one cycle, and is granted alongside processor accesses to the other two banks.
- R5: When any granted processor access uses a bank of the DMA pair, the DMA request is not granted in that cycle (outside the R6 case).
- R6: An aligned DMA request that has gone ungranted for 4 consecutive cycles is granted in the 5th cycle, and processor requests to its two banks are not granted in that cycle.
- R7: A granted read returns its data on the same port in the next cycle with that port's valid high; writes produce no valid, and read data outputs are zero whenever their valid is low.
- R8: Writes update only the bytes whose byte-enable bit is set (bit i covers data bits 8i+7:8i).
- R9: A DMA request with A[2:0] not zero is accepted (DMA grant high) without enabling any bank, and the DMA error output is high in the next cycle with the DMA valid low.
- R10: After reset all valid outputs, the DMA error output and the starvation history are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 2 | Request per processor port |
| cpuWe | input | 2 | Write enable per processor port |
| cpuAddr | input | 2x AW | Byte address per processor port |
| cpuWdata | input | 2x32 | Write data per processor port |
| cpuBe | input | 2x4 | Byte enables per processor port |
| cpuGnt | output | 2 | Grant per processor port, same cycle as request |
| cpuRvalid | output | 2 | Read data valid per processor port |
| cpuRdata | output | 2x32 | Read data per processor port |
| dmaReq | input | 1 | DMA request |
| dmaWe | input | 1 | DMA write enable |
| dmaAddr | input | AW | DMA byte address, 8-byte aligned |
| dmaWdata | input | 64 | DMA write data |
| dmaBe | input | 8 | DMA byte enables |
| dmaGnt | output | 1 | DMA grant (also high when a misaligned request is consumed) |
| dmaRvalid | output | 1 | DMA read data valid |
| dmaRdata | output | 64 | DMA read data |
| dmaErr | output | 1 | Misalignment error response |
| bankEn | output | 4 | Enable per bank |
| bankWe | output | 4 | Write enable per bank |
| bankAddr | output | 4x(AW-4) | Row address per bank |
| bankWdata | output | 4x32 | Write data per bank |
| bankBe | output | 4x4 | Byte enables per bank |
| bankRdata | input | 4x32 | Read data per bank, one cycle after enable |

## Verification
A wrong owner decision is visible in the same cycle on the grant outputs, and one cycle later as wrong or missing read data, since every read returns through a registered bank index. A stale starvation count shows as a DMA grant arriving a cycle early or late in a run of lost cycles, or as a processor grant dropped when no DMA was waiting. A corrupt return register surfaces on the very next cycle as a valid without a prior grant, or as data from a neighbouring bank, which the bench exposes by reading words that were written with distinct patterns in every bank.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;

  localparam int NUM_BANKS  = 4;
  localparam int NUM_CPU    = 2;
  localparam int BANK_DW    = 32;
  localparam int BANK_BW    = BANK_DW / 8;
  localparam int BANK_SEL_W = $clog2(NUM_BANKS);
  localparam int PAIR_W     = BANK_SEL_W - 1;
  localparam int BYTE_LSB   = $clog2(BANK_BW);
  localparam int ROW_LSB    = BYTE_LSB + BANK_SEL_W;
  localparam int DMA_DW     = 2 * BANK_DW;
  localparam int DMA_BW     = 2 * BANK_BW;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU0 = 2'd1,
    OWN_CPU1 = 2'd2,
    OWN_DMA  = 2'd3
  } bankOwner_e;

  // Strobes from the control to the datapath, valid in the grant cycle.
  typedef struct packed {
    bankOwner_e [NUM_BANKS-1:0] owner;
    logic [NUM_CPU-1:0]         cpuRd;
    logic                       dmaRd;
    logic                       dmaErr;
    logic [PAIR_W-1:0]          dmaPair;
  } arbStrobe_t;

endpackage

// File: rtl/tcm_arb_ctrl.sv
module tcm_arb_ctrl
  import tcm_arb_pkg::*;
#(
  parameter int STARVE_LIMIT = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_CPU-1:0]                   cpuReq,
  input  logic [NUM_CPU-1:0]                   cpuWe,
  input  logic [NUM_CPU-1:0][BANK_SEL_W-1:0]   cpuBank,
  input  logic                                 dmaReq,
  input  logic                                 dmaWe,
  input  logic [ROW_LSB-1:0]                   dmaLow,
  output logic [NUM_CPU-1:0]                   cpuGnt,
  output logic                                 dmaGnt,
  output arbStrobe_t                           strb
);

  localparam int CNT_W = $clog2(STARVE_LIMIT + 1);

  logic [CNT_W-1:0]                    starveCnt;
  logic [NUM_CPU-1:0][NUM_BANKS-1:0]   cpuHit;
  logic [NUM_BANKS-1:0]                dmaMask;
  logic [NUM_BANKS-1:0]                busy;
  logic [PAIR_W-1:0]                   dmaPair;
  logic                                dmaMis;
  logic                                dmaOk;
  logic                                boost;
  logic                                dmaWin;
  logic [NUM_CPU-1:0]                  cpuWin;

  assign dmaPair = dmaLow[ROW_LSB-1:BYTE_LSB+1];
  assign dmaMis  = |dmaLow[BYTE_LSB:0];
  assign dmaOk   = dmaReq && !dmaMis;
  assign boost   = dmaOk && (starveCnt == CNT_W'(STARVE_LIMIT));

  // Decode requests into bank masks.
  always_comb begin
    cpuHit  = '0;
    dmaMask = '0;
    for (int p = 0; p < NUM_CPU; p++) begin
      cpuHit[p][cpuBank[p]] = 1'b1;
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      dmaMask[b] = ((BANK_SEL_W'(b) >> 1) == {1'b0, dmaPair});
    end
  end

  // Fixed priority: boosted DMA, then port 0, port 1, normal DMA.
  always_comb begin
    busy   = '0;
    cpuWin = '0;
    dmaWin = 1'b0;
    if (boost) begin
      dmaWin = 1'b1;
      busy   = dmaMask;
    end
    for (int p = 0; p < NUM_CPU; p++) begin
      if (cpuReq[p] && ((busy & cpuHit[p]) == '0)) begin
        cpuWin[p] = 1'b1;
        busy      = busy | cpuHit[p];
      end
    end
    if (!boost) begin
      dmaWin = dmaOk && ((busy & dmaMask) == '0);
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (dmaWin && dmaMask[b])              strb.owner[b] = OWN_DMA;
      else if (cpuWin[0] && cpuHit[0][b])    strb.owner[b] = OWN_CPU0;
      else if (cpuWin[1] && cpuHit[1][b])    strb.owner[b] = OWN_CPU1;
      else                                   strb.owner[b] = OWN_NONE;
    end
    strb.cpuRd   = cpuWin & ~cpuWe;
    strb.dmaRd   = dmaWin && !dmaWe;
    strb.dmaErr  = dmaReq && dmaMis;
    strb.dmaPair = dmaPair;
  end

  assign cpuGnt = cpuWin;
  assign dmaGnt = dmaWin || (dmaReq && dmaMis);

  // Consecutive-loss counter for the aligned DMA request.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      starveCnt <= '0;
    end else if (!dmaOk || dmaWin) begin
      starveCnt <= '0;
    end else if (starveCnt != CNT_W'(STARVE_LIMIT)) begin
      starveCnt <= starveCnt + 1'b1;
    end
  end

endmodule

// File: rtl/tcm_arb_dpath.sv
module tcm_arb_dpath
  import tcm_arb_pkg::*;
#(
  parameter int ROW_W = 12
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  arbStrobe_t                           strb,
  input  logic [NUM_CPU-1:0]                   cpuWe,
  input  logic [NUM_CPU-1:0][BANK_SEL_W-1:0]   cpuBank,
  input  logic [NUM_CPU-1:0][ROW_W-1:0]        cpuRow,
  input  logic [NUM_CPU-1:0][BANK_DW-1:0]      cpuWdata,
  input  logic [NUM_CPU-1:0][BANK_BW-1:0]      cpuBe,
  input  logic                                 dmaWe,
  input  logic [ROW_W-1:0]                     dmaRow,
  input  logic [DMA_DW-1:0]                    dmaWdata,
  input  logic [DMA_BW-1:0]                    dmaBe,
  output logic [NUM_BANKS-1:0]                 bankEn,
  output logic [NUM_BANKS-1:0]                 bankWe,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]      bankAddr,
  output logic [NUM_BANKS-1:0][BANK_DW-1:0]    bankWdata,
  output logic [NUM_BANKS-1:0][BANK_BW-1:0]    bankBe,
  input  logic [NUM_BANKS-1:0][BANK_DW-1:0]    bankRdata,
  output logic [NUM_CPU-1:0]                   cpuRvalid,
  output logic [NUM_CPU-1:0][BANK_DW-1:0]      cpuRdata,
  output logic                                 dmaRvalid,
  output logic [DMA_DW-1:0]                    dmaRdata,
  output logic                                 dmaErr
);

  // Bank-side muxing, one copy per bank.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int HALF = b % 2;
    logic               en;
    logic               we;
    logic [ROW_W-1:0]   row;
    logic [BANK_DW-1:0] wd;
    logic [BANK_BW-1:0] be;

    always_comb begin
      en  = 1'b1;
      we  = 1'b0;
      row = '0;
      wd  = '0;
      be  = '0;
      case (strb.owner[b])
        OWN_CPU0: begin
          we = cpuWe[0]; row = cpuRow[0]; wd = cpuWdata[0]; be = cpuBe[0];
        end
        OWN_CPU1: begin
          we = cpuWe[1]; row = cpuRow[1]; wd = cpuWdata[1]; be = cpuBe[1];
        end
        OWN_DMA: begin
          we  = dmaWe;
          row = dmaRow;
          wd  = dmaWdata[HALF*BANK_DW +: BANK_DW];
          be  = dmaBe[HALF*BANK_BW +: BANK_BW];
        end
        default: en = 1'b0;
      endcase
    end

    assign bankEn[b]    = en;
    assign bankWe[b]    = we;
    assign bankAddr[b]  = row;
    assign bankWdata[b] = wd;
    assign bankBe[b]    = be;
  end

  // Return path: remember which bank each read used.
  logic [NUM_CPU-1:0]                 cpuRvQ;
  logic [NUM_CPU-1:0][BANK_SEL_W-1:0] cpuBankQ;
  logic                               dmaRvQ;
  logic [PAIR_W-1:0]                  dmaPairQ;
  logic                               dmaErrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRvQ   <= '0;
      cpuBankQ <= '0;
      dmaRvQ   <= 1'b0;
      dmaPairQ <= '0;
      dmaErrQ  <= 1'b0;
    end else begin
      cpuRvQ   <= strb.cpuRd;
      cpuBankQ <= cpuBank;
      dmaRvQ   <= strb.dmaRd;
      dmaPairQ <= strb.dmaPair;
      dmaErrQ  <= strb.dmaErr;
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_CPU; p++) begin
      cpuRdata[p] = cpuRvQ[p] ? bankRdata[cpuBankQ[p]] : '0;
    end
    dmaRdata = dmaRvQ ? {bankRdata[{dmaPairQ, 1'b1}], bankRdata[{dmaPairQ, 1'b0}]} : '0;
  end

  assign cpuRvalid = cpuRvQ;
  assign dmaRvalid = dmaRvQ;
  assign dmaErr    = dmaErrQ;

endmodule

// File: rtl/tcm_bank_arbiter.sv
module tcm_bank_arbiter
  import tcm_arb_pkg::*;
#(
  parameter int AW           = 16,
  parameter int STARVE_LIMIT = 4
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic [NUM_CPU-1:0]                          cpuReq,
  input  logic [NUM_CPU-1:0]                          cpuWe,
  input  logic [NUM_CPU-1:0][AW-1:0]                  cpuAddr,
  input  logic [NUM_CPU-1:0][BANK_DW-1:0]             cpuWdata,
  input  logic [NUM_CPU-1:0][BANK_BW-1:0]             cpuBe,
  output logic [NUM_CPU-1:0]                          cpuGnt,
  output logic [NUM_CPU-1:0]                          cpuRvalid,
  output logic [NUM_CPU-1:0][BANK_DW-1:0]             cpuRdata,
  input  logic                                        dmaReq,
  input  logic                                        dmaWe,
  input  logic [AW-1:0]                               dmaAddr,
  input  logic [DMA_DW-1:0]                           dmaWdata,
  input  logic [DMA_BW-1:0]                           dmaBe,
  output logic                                        dmaGnt,
  output logic                                        dmaRvalid,
  output logic [DMA_DW-1:0]                           dmaRdata,
  output logic                                        dmaErr,
  output logic [NUM_BANKS-1:0]                        bankEn,
  output logic [NUM_BANKS-1:0]                        bankWe,
  output logic [NUM_BANKS-1:0][AW-ROW_LSB-1:0]        bankAddr,
  output logic [NUM_BANKS-1:0][BANK_DW-1:0]           bankWdata,
  output logic [NUM_BANKS-1:0][BANK_BW-1:0]           bankBe,
  input  logic [NUM_BANKS-1:0][BANK_DW-1:0]           bankRdata
);

  localparam int ROW_W = AW - ROW_LSB;

  logic [NUM_CPU-1:0][BANK_SEL_W-1:0] cpuBank;
  logic [NUM_CPU-1:0][ROW_W-1:0]      cpuRow;
  logic [NUM_CPU-1:0][BYTE_LSB-1:0]   unusedByteBits;
  arbStrobe_t                         strb;

  for (genvar p = 0; p < NUM_CPU; p++) begin : g_split
    assign cpuBank[p]        = cpuAddr[p][ROW_LSB-1:BYTE_LSB];
    assign cpuRow[p]         = cpuAddr[p][AW-1:ROW_LSB];
    assign unusedByteBits[p] = cpuAddr[p][BYTE_LSB-1:0];
  end

  tcm_arb_ctrl #(
    .STARVE_LIMIT(STARVE_LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuReq  (cpuReq),
    .cpuWe   (cpuWe),
    .cpuBank (cpuBank),
    .dmaReq  (dmaReq),
    .dmaWe   (dmaWe),
    .dmaLow  (dmaAddr[ROW_LSB-1:0]),
    .cpuGnt  (cpuGnt),
    .dmaGnt  (dmaGnt),
    .strb    (strb)
  );

  tcm_arb_dpath #(
    .ROW_W(ROW_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuWe     (cpuWe),
    .cpuBank   (cpuBank),
    .cpuRow    (cpuRow),
    .cpuWdata  (cpuWdata),
    .cpuBe     (cpuBe),
    .dmaWe     (dmaWe),
    .dmaRow    (dmaAddr[AW-1:ROW_LSB]),
    .dmaWdata  (dmaWdata),
    .dmaBe     (dmaBe),
    .bankEn    (bankEn),
    .bankWe    (bankWe),
    .bankAddr  (bankAddr),
    .bankWdata (bankWdata),
    .bankBe    (bankBe),
    .bankRdata (bankRdata),
    .cpuRvalid (cpuRvalid),
    .cpuRdata  (cpuRdata),
    .dmaRvalid (dmaRvalid),
    .dmaRdata  (dmaRdata),
    .dmaErr    (dmaErr)
  );

endmodule

// File: rtl/tcm_bank_arbiter_chk.sv
module tcm_bank_arbiter_chk
  import tcm_arb_pkg::*;
#(
  parameter int AW           = 16,
  parameter int STARVE_LIMIT = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_CPU-1:0]         cpuReq,
  input logic [NUM_CPU-1:0]         cpuWe,
  input logic [NUM_CPU-1:0][AW-1:0] cpuAddr,
  input logic [NUM_CPU-1:0]         cpuGnt,
  input logic [NUM_CPU-1:0]         cpuRvalid,
  input logic                       dmaReq,
  input logic [AW-1:0]              dmaAddr,
  input logic                       dmaGnt,
  input logic                       dmaRvalid,
  input logic                       dmaErr,
  input logic [NUM_BANKS-1:0]       bankEn
);

  localparam int CNT_W = $clog2(STARVE_LIMIT + 1);

  logic dmaAligned;
  logic dmaMisal;
  logic [CNT_W-1:0] loseCnt;

  assign dmaAligned = dmaReq && (dmaAddr[BYTE_LSB:0] == '0);
  assign dmaMisal   = dmaReq && (dmaAddr[BYTE_LSB:0] != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           loseCnt <= '0;
    else if (!dmaAligned || dmaGnt)      loseCnt <= '0;
    else if (loseCnt != CNT_W'(STARVE_LIMIT)) loseCnt <= loseCnt + 1'b1;
  end

  assert_bank_enabled_R1: assert property (@(posedge clk) disable iff (!rstN)
    cpuGnt[0] |-> bankEn[cpuAddr[0][ROW_LSB-1:BYTE_LSB]]);

  assert_dual_distinct_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuGnt == 2'b11) |-> (cpuAddr[0][ROW_LSB-1:BYTE_LSB] != cpuAddr[1][ROW_LSB-1:BYTE_LSB]));

  assert_port0_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq[0] && !cpuGnt[0]) |-> (dmaGnt && dmaAligned));

  assert_cpu0_dma_disjoint_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaGnt && dmaAligned && cpuGnt[0]) |->
      (cpuAddr[0][ROW_LSB-1:BYTE_LSB+1] != dmaAddr[ROW_LSB-1:BYTE_LSB+1]));

  assert_cpu1_dma_disjoint_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaGnt && dmaAligned && cpuGnt[1]) |->
      (cpuAddr[1][ROW_LSB-1:BYTE_LSB+1] != dmaAddr[ROW_LSB-1:BYTE_LSB+1]));

  assert_starve_served_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAligned && (loseCnt == CNT_W'(STARVE_LIMIT))) |-> dmaGnt);

  assert_read_return_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq[0] && cpuGnt[0] && !cpuWe[0]) |=> cpuRvalid[0]);

  assert_misalign_nobank_R9: assert property (@(posedge clk) disable iff (!rstN)
    dmaMisal |-> ($countones(bankEn) == $countones(cpuGnt)));

  assert_misalign_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    dmaMisal |=> (dmaErr && !dmaRvalid));

endmodule

bind tcm_bank_arbiter tcm_bank_arbiter_chk #(
  .AW(AW),
  .STARVE_LIMIT(STARVE_LIMIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuReq    (cpuReq),
  .cpuWe     (cpuWe),
  .cpuAddr   (cpuAddr),
  .cpuGnt    (cpuGnt),
  .cpuRvalid (cpuRvalid),
  .dmaReq    (dmaReq),
  .dmaAddr   (dmaAddr),
  .dmaGnt    (dmaGnt),
  .dmaRvalid (dmaRvalid),
  .dmaErr    (dmaErr),
  .bankEn    (bankEn)
);

// File: tb/tcm_bank_arbiter_tb.sv
module tcm_bank_arbiter_tb;
  import tcm_arb_pkg::*;

  localparam int AW    = 16;
  localparam int ROW_W = AW - ROW_LSB;
  localparam int DEPTH = 64;
  localparam int NVEC  = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [NUM_CPU-1:0]                   cpuReq, cpuWe, cpuGnt, cpuRvalid;
  logic [NUM_CPU-1:0][AW-1:0]           cpuAddr;
  logic [NUM_CPU-1:0][BANK_DW-1:0]      cpuWdata, cpuRdata;
  logic [NUM_CPU-1:0][BANK_BW-1:0]      cpuBe;
  logic                                 dmaReq, dmaWe, dmaGnt, dmaRvalid, dmaErr;
  logic [AW-1:0]                        dmaAddr;
  logic [DMA_DW-1:0]                    dmaWdata, dmaRdata;
  logic [DMA_BW-1:0]                    dmaBe;
  logic [NUM_BANKS-1:0]                 bankEn, bankWe;
  logic [NUM_BANKS-1:0][ROW_W-1:0]      bankAddr;
  logic [NUM_BANKS-1:0][BANK_DW-1:0]    bankWdata, bankRdata;
  logic [NUM_BANKS-1:0][BANK_BW-1:0]    bankBe;

  tcm_bank_arbiter #(.AW(AW), .STARVE_LIMIT(4)) u_dut (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuBe(cpuBe),
    .cpuGnt(cpuGnt), .cpuRvalid(cpuRvalid), .cpuRdata(cpuRdata),
    .dmaReq(dmaReq), .dmaWe(dmaWe), .dmaAddr(dmaAddr), .dmaWdata(dmaWdata), .dmaBe(dmaBe),
    .dmaGnt(dmaGnt), .dmaRvalid(dmaRvalid), .dmaRdata(dmaRdata), .dmaErr(dmaErr),
    .bankEn(bankEn), .bankWe(bankWe), .bankAddr(bankAddr), .bankWdata(bankWdata),
    .bankBe(bankBe), .bankRdata(bankRdata)
  );

  // Synchronous single-port bank models.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sram
    logic [BANK_DW-1:0] mem [DEPTH];
    initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
      bankRdata[b] = '0;
    end
    always @(posedge clk) begin
      if (bankEn[b]) begin
        if (bankWe[b]) begin
          for (int k = 0; k < BANK_BW; k++)
            if (bankBe[b][k]) mem[bankAddr[b][5:0]][8*k +: 8] <= bankWdata[b][8*k +: 8];
        end else begin
          bankRdata[b] <= mem[bankAddr[b][5:0]];
        end
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic idle();
    cpuReq = '0; cpuWe = '0; cpuAddr = '0; cpuWdata = '0; cpuBe = '0;
    dmaReq = 1'b0; dmaWe = 1'b0; dmaAddr = '0; dmaWdata = '0; dmaBe = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cpuOp(input int p, input logic we, input logic [7:0] a,
                       input logic [31:0] d, input logic [3:0] be);
    cpuReq[p] = 1'b1; cpuWe[p] = we; cpuAddr[p] = AW'(a); cpuWdata[p] = d; cpuBe[p] = be;
  endtask

  task automatic dmaOp(input logic we, input logic [7:0] a,
                       input logic [63:0] d, input logic [7:0] be);
    dmaReq = 1'b1; dmaWe = we; dmaAddr = AW'(a); dmaWdata = d; dmaBe = be;
  endtask

  // Vector: {req0, addr0, req1, addr1, dmaReq, dmaAddr, expected {dmaGnt, gnt1, gnt0}}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 1'b1, 8'h04, 1'b0, 8'h00, 3'b011},  // R2 different banks
    {1'b1, 8'h08, 1'b1, 8'h18, 1'b0, 8'h00, 3'b001},  // R3 same bank 2
    {1'b1, 8'h00, 1'b1, 8'h04, 1'b1, 8'h08, 3'b111},  // R4 all four banks busy
    {1'b1, 8'h04, 1'b0, 8'h00, 1'b1, 8'h00, 3'b001},  // R5 port 0 on DMA pair
    {1'b0, 8'h00, 1'b1, 8'h0C, 1'b1, 8'h08, 3'b010},  // R5 port 1 on DMA pair
    {1'b1, 8'h14, 1'b1, 8'h08, 1'b1, 8'h00, 3'b011},  // R5 bank 1 shared
    {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h10, 3'b100},  // R4 DMA alone
    {1'b1, 8'h0C, 1'b1, 8'h0C, 1'b1, 8'h00, 3'b101},  // R3 R4 port 1 stalled, DMA free
    {1'b1, 8'h00, 1'b1, 8'h10, 1'b1, 8'h08, 3'b101}   // R3 R4 bank 0 conflict
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    finishRun();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    chkEq("R10 cpuRvalid after reset", 64'(cpuRvalid), 64'h0);
    chkEq("R10 dmaRvalid after reset", 64'(dmaRvalid), 64'h0);
    chkEq("R10 dmaErr after reset", 64'(dmaErr), 64'h0);
    chkEq("R10 grants idle", 64'({dmaGnt, cpuGnt}), 64'h0);

    // Grant table walk, one idle cycle between vectors.
    for (int v = 0; v < NVEC; v++) begin
      idle();
      if (VEC[v][29]) cpuOp(0, 1'b0, VEC[v][28:21], '0, 4'hF);
      if (VEC[v][20]) cpuOp(1, 1'b0, VEC[v][19:12], '0, 4'hF);
      if (VEC[v][11]) dmaOp(1'b0, VEC[v][10:3], '0, 8'hFF);
      #1;
      chkEq($sformatf("R2 R3 R4 R5 grant vector %0d", v), 64'({dmaGnt, cpuGnt}), 64'(VEC[v][2:0]));
      step();
      idle();
      step();
    end

    // R8 byte-enable writes, R7 writes give no valid
    cpuOp(0, 1'b1, 8'h00, 32'h11223344, 4'hF);
    step();
    chkEq("R7 no valid after write", 64'(cpuRvalid[0]), 64'h0);
    idle();
    cpuOp(0, 1'b1, 8'h00, 32'hAABBCCDD, 4'b0010);
    step();
    idle();
    cpuOp(1, 1'b1, 8'h04, 32'h55667788, 4'hF);
    #1;
    chkEq("R1 port 1 write to bank 1 enables it", 64'(bankEn), 64'h2);
    step();
    idle();
    cpuOp(0, 1'b0, 8'h00, '0, 4'hF);
    step();
    idle();
    chkEq("R7 read valid", 64'(cpuRvalid[0]), 64'h1);
    chkEq("R8 merged bytes", 64'(cpuRdata[0]), 64'h1122CC44);

    // R4 DMA write, then three readers at once
    dmaOp(1'b1, 8'h08, 64'hCAFE0003_BEEF0002, 8'hFF);
    step();
    idle();
    cpuOp(0, 1'b0, 8'h00, '0, 4'hF);
    cpuOp(1, 1'b0, 8'h04, '0, 4'hF);
    dmaOp(1'b0, 8'h08, '0, 8'hFF);
    #1;
    chkEq("R4 full-width grants", 64'({dmaGnt, cpuGnt}), 64'h7);
    step();
    idle();
    chkEq("R7 port 0 data", 64'(cpuRdata[0]), 64'h1122CC44);
    chkEq("R7 port 1 data", 64'(cpuRdata[1]), 64'h55667788);
    chkEq("R4 DMA data halves", dmaRdata, 64'hCAFE0003_BEEF0002);
    dmaOp(1'b0, 8'h00, '0, 8'hFF);
    step();
    idle();
    chkEq("R1 R4 DMA sees banks 1:0", dmaRdata, 64'h55667788_1122CC44);

    // R9 misaligned DMA write alongside a processor read
    cpuOp(0, 1'b0, 8'h00, '0, 4'hF);
    dmaOp(1'b1, 8'h0C, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    #1;
    chkEq("R9 misaligned consumed", 64'({dmaGnt, cpuGnt}), 64'h5);
    chkEq("R9 only processor bank enabled", 64'(bankEn), 64'h1);
    step();
    idle();
    chkEq("R9 error response", 64'({dmaErr, dmaRvalid}), 64'h2);
    chkEq("R9 processor unaffected", 64'(cpuRdata[0]), 64'h1122CC44);
    dmaOp(1'b0, 8'h08, '0, 8'hFF);
    step();
    idle();
    chkEq("R9 banks untouched", dmaRdata, 64'hCAFE0003_BEEF0002);
    chkEq("R9 error clears", 64'(dmaErr), 64'h0);

    // R6 starvation: processor holds bank 0, DMA wants banks 1:0
    cpuOp(0, 1'b0, 8'h00, '0, 4'hF);
    dmaOp(1'b0, 8'h00, '0, 8'hFF);
    for (int i = 1; i <= 4; i++) begin
      #1;
      chkEq($sformatf("R5 DMA loses cycle %0d", i), 64'({dmaGnt, cpuGnt[0]}), 64'h1);
      step();
    end
    #1;
    chkEq("R6 DMA boosted on 5th cycle", 64'({dmaGnt, cpuGnt[0]}), 64'h2);
    step();
    dmaReq = 1'b0;
    #1;
    chkEq("R6 boosted read returns", dmaRdata, 64'h55667788_1122CC44);
    chkEq("R6 processor granted after boost", 64'(cpuGnt[0]), 64'h1);
    step();
    idle();
    step();
    chkEq("R7 data zero without valid", 64'({cpuRdata[0], cpuRdata[1]}), 64'h0);
    chkEq("R7 DMA data zero without valid", dmaRdata, 64'h0);

    finishRun();
  end

endmodule